// File: doc/BRIEF.md
# Frame-Locked Clock Prescaler with Standby Control

This block runs on the master clock of a voice-band codec. It works out the master clock rate by counting master clock cycles between successive rising edges of the transmit frame sync. The block supports eight rates, and each has a nominal count per 8 kHz frame. Once a rate is locked, the block produces two outputs:
- a 256 kHz tick stream, with exactly 32 ticks per frame spread evenly over the measured frame length, which also covers the non-integer ratios;
- an 8 kHz sample strobe that is aligned to the frame sync edge.

The block also handles the power states. The power-up input forces the block down. It enters standby when both frame syncs stay quiet for longer than a frame. After any down state, a ready flag tells the serial transmitter when it may drive its line again. Both frame syncs are sampled on the master clock, so they must be synchronous to it.

Top module: `frame_clock_gen`

## Requirements
- R1: After reset, with pwr_up high, rate_bad is 1, rate_code is 0, and tick_256k, strobe_8k, standby and tx_ready are all 0.
- R2: A frame period is the number of mclk cycles between two successive rising edges of fs_tx as sampled on mclk. The nominal periods 32, 64, 192, 193, 256, 320, 512 and 600 select rate_code 0 through 7 respectively, with rate_bad 0.
- R3: A period that is within ±1 of a nominal value selects that rate. When a period matches one entry exactly and lies within ±1 of another, the exact match wins. Any other period is unsupported and drives rate_bad to 1.
- R4: When locked with a steady period N, exactly 32 tick_256k pulses occur between successive strobes. Every gap between ticks is floor(N/32) or ceil(N/32) cycles.
- R5: strobe_8k pulses once per frame, in the cycle after the mclk edge that first samples fs_tx high. It pulses only when the block is locked, powered up and not in standby, so successive strobes are N cycles apart.
- R6: rate_code and rate_bad change only when two consecutive frame measurements agree on a new value. A single differing frame leaves them unchanged.
- R7: standby rises after fs_tx and fs_rx have both been low for L consecutive sampled cycles. L is the nominal period plus 2 when locked, and 608 when unlocked. Pulses on fs_rx alone keep standby low. While standby is high, ticks and strobes stop.
- R8: A rising edge on fs_tx clears standby.
- R9: tx_ready rises on the third rising edge of fs_tx after a down state ends. Down states are reset, pwr_up low and standby, and the rising edge that ends standby counts as the first. tx_ready clears on power-down or on standby entry.
- R10: While pwr_up is low, standby is 1 at once, and tick_256k, strobe_8k and tx_ready are 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fs_tx | input | 1 | Transmit frame sync, synchronous to mclk |
| fs_rx | input | 1 | Receive frame sync, synchronous to mclk |
| pwr_up | input | 1 | High to power up, low to power down |
| tick_256k | output | 1 | One-cycle internal 256 kHz tick |
| strobe_8k | output | 1 | One-cycle 8 kHz sample strobe aligned to fs_tx |
| rate_code | output | 3 | Index of the locked master clock rate |
| rate_bad | output | 1 | High when no supported rate is locked |
| standby | output | 1 | High in standby or while powered down |
| tx_ready | output | 1 | Serial transmit output may be driven |

## Verification
The bench builds the block with its default parameters: 32 ticks per frame, a 10-bit period counter and an unlocked standby limit of 608. These values let the bench sweep all eight nominal frame lengths, including the fractional ratios of 193 and 600 cycles, within a few thousand cycles each. At those lengths it also checks the ±1 edges of the lookup, the 192/193 overlap, a single stray frame, an unsupported period, the exact standby cycle and the ready count. The expected tick count, tick gaps, strobe spacing and standby cycle are computed from N alone.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    localparam int NUM_RATES    = 8;
    localparam int CNT_W        = 10;
    localparam int RATE_TOL     = 1;
    localparam int IDLE_DEFAULT = 608;
    localparam int IDLE_MARGIN  = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic       bad;
        logic [2:0] code;
    } rate_sel_t;

    // Master clock cycles per 8 kHz frame for each supported rate.
    function automatic cnt_t nominal_count(input logic [2:0] code);
        case (code)
            3'd0:    return cnt_t'(32);
            3'd1:    return cnt_t'(64);
            3'd2:    return cnt_t'(192);
            3'd3:    return cnt_t'(193);
            3'd4:    return cnt_t'(256);
            3'd5:    return cnt_t'(320);
            3'd6:    return cnt_t'(512);
            default: return cnt_t'(600);
        endcase
    endfunction

    // Exact match wins; otherwise the lowest code within tolerance.
    function automatic rate_sel_t classify(input cnt_t n);
        rate_sel_t r;
        r.bad  = 1'b1;
        r.code = 3'd0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            int d;
            d = int'(n) - int'(nominal_count(3'(i)));
            if (d >= -RATE_TOL && d <= RATE_TOL) begin
                r.bad  = 1'b0;
                r.code = 3'(i);
            end
        end
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (n == nominal_count(3'(i))) begin
                r.bad  = 1'b0;
                r.code = 3'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fcg_rate_meter.sv
module fcg_rate_meter
    import fcg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fs_tx,
    output logic      rise_o,
    output rate_sel_t cur_o,
    output cnt_t      period_o
);

    logic      fs_q;
    logic      seen_q;
    logic      cand_vld_q;
    cnt_t      per_q;
    cnt_t      period_q;
    rate_sel_t cand_q;
    rate_sel_t cur_q;
    rate_sel_t meas;
    rate_sel_t cur_d;
    logic      rise;

    assign rise = fs_tx & ~fs_q;
    assign meas = classify(per_q);

    always_comb begin
        cur_d = cur_q;
        if (rise && seen_q && cand_vld_q && (meas == cand_q))
            cur_d = meas;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q       <= 1'b0;
            seen_q     <= 1'b0;
            cand_vld_q <= 1'b0;
            per_q      <= '0;
            period_q   <= '0;
            cand_q     <= '{bad: 1'b1, code: 3'd0};
            cur_q      <= '{bad: 1'b1, code: 3'd0};
        end else begin
            fs_q  <= fs_tx;
            cur_q <= cur_d;
            if (rise) begin
                per_q  <= cnt_t'(1);
                seen_q <= 1'b1;
                if (seen_q) begin
                    cand_q     <= meas;
                    cand_vld_q <= 1'b1;
                    if (!meas.bad && (meas == cur_d))
                        period_q <= per_q;
                end
            end else if (per_q != '1) begin
                per_q <= per_q + cnt_t'(1);
            end
        end
    end

    assign rise_o   = rise;
    assign cur_o    = cur_q;
    assign period_o = period_q;

    // R6
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(cur_q));

endmodule

// File: rtl/fcg_tick_gen.sv
module fcg_tick_gen
    import fcg_pkg::*;
#(
    parameter int TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic en,
    input  cnt_t period,
    output logic tick_o,
    output logic strobe_o
);

    localparam int ACC_W = CNT_W + 1;
    localparam int TC_W  = $clog2(TICKS + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] per_ext;
    logic [TC_W-1:0]  tcnt_q;
    logic [TC_W-1:0]  tbase;
    logic             over;
    logic             hit;

    assign per_ext = {1'b0, period};
    assign base    = rise ? '0 : acc_q;
    assign tbase   = rise ? '0 : tcnt_q;
    assign sum     = base + ACC_W'(TICKS);
    assign over    = (sum >= per_ext);
    assign hit     = over && (tbase < TC_W'(TICKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            tcnt_q   <= '0;
            tick_o   <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            acc_q    <= over ? (sum - per_ext) : sum;
            tcnt_q   <= tbase + TC_W'(hit);
            tick_o   <= hit && en;
            strobe_o <= rise && en;
        end
    end

    // R4
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(en));

    // R5
    strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> (strobe_o == $past(en)));

endmodule

// File: rtl/fcg_power_seq.sv
module fcg_power_seq
    import fcg_pkg::*;
#(
    parameter int IDLE_UNLOCKED = IDLE_DEFAULT,
    parameter int READY_EDGES   = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_up,
    input  logic      fs_tx,
    input  logic      fs_rx,
    input  logic      rise,
    input  rate_sel_t cur,
    output logic      standby_o,
    output logic      active_o,
    output logic      tx_ready_o
);

    localparam int LW   = CNT_W + 1;
    localparam int RC_W = $clog2(READY_EDGES + 1);

    cnt_t            idle_q;
    logic            idle_stby_q;
    logic [RC_W-1:0] rcnt_q;
    logic            ready_q;
    logic [LW-1:0]   lim;
    logic            fs_any;
    logic            go_idle;

    assign fs_any  = fs_tx | fs_rx;
    assign lim     = cur.bad ? LW'(IDLE_UNLOCKED)
                             : ({1'b0, nominal_count(cur.code)} + LW'(IDLE_MARGIN));
    assign go_idle = !fs_any && (({1'b0, idle_q} + LW'(1)) >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q      <= '0;
            idle_stby_q <= 1'b0;
            rcnt_q      <= '0;
            ready_q     <= 1'b0;
        end else begin
            if (fs_any)
                idle_q <= '0;
            else if (idle_q != '1)
                idle_q <= idle_q + cnt_t'(1);

            if (rise)
                idle_stby_q <= 1'b0;
            else if (go_idle)
                idle_stby_q <= 1'b1;

            if (!pwr_up || go_idle) begin
                rcnt_q  <= '0;
                ready_q <= 1'b0;
            end else if (rise) begin
                if (rcnt_q == RC_W'(READY_EDGES - 1))
                    ready_q <= 1'b1;
                else
                    rcnt_q <= rcnt_q + RC_W'(1);
            end
        end
    end

    assign standby_o  = idle_stby_q | ~pwr_up;
    assign active_o   = pwr_up & ~idle_stby_q;
    assign tx_ready_o = ready_q;

    // R9
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        idle_stby_q |-> !ready_q);

    // R9
    ready_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(rise));

    // R8
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !idle_stby_q);

endmodule

// File: rtl/frame_clock_gen.sv
module frame_clock_gen
    import fcg_pkg::*;
#(
    parameter int TICKS         = 32,
    parameter int IDLE_UNLOCKED = IDLE_DEFAULT
) (
    input  logic       mclk,
    input  logic       rst,
    input  logic       fs_tx,
    input  logic       fs_rx,
    input  logic       pwr_up,
    output logic       tick_256k,
    output logic       strobe_8k,
    output logic [2:0] rate_code,
    output logic       rate_bad,
    output logic       standby,
    output logic       tx_ready
);

    logic      rise;
    rate_sel_t cur;
    cnt_t      period;
    logic      active;

    fcg_rate_meter u_meter (
        .clk      (mclk),
        .rst      (rst),
        .fs_tx    (fs_tx),
        .rise_o   (rise),
        .cur_o    (cur),
        .period_o (period)
    );

    fcg_tick_gen #(.TICKS(TICKS)) u_ticks (
        .clk      (mclk),
        .rst      (rst),
        .rise     (rise),
        .en       (active & ~cur.bad),
        .period   (period),
        .tick_o   (tick_256k),
        .strobe_o (strobe_8k)
    );

    fcg_power_seq #(.IDLE_UNLOCKED(IDLE_UNLOCKED)) u_power (
        .clk        (mclk),
        .rst        (rst),
        .pwr_up     (pwr_up),
        .fs_tx      (fs_tx),
        .fs_rx      (fs_rx),
        .rise       (rise),
        .cur        (cur),
        .standby_o  (standby),
        .active_o   (active),
        .tx_ready_o (tx_ready)
    );

    assign rate_code = cur.code;
    assign rate_bad  = cur.bad;

    // R10
    pwrdn_quiet_chk: assert property (@(posedge mclk) disable iff (rst)
        !pwr_up |=> (!tick_256k && !strobe_8k && !tx_ready));

endmodule

// File: tb/frame_clock_gen_bench.sv
module frame_clock_gen_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       fs_tx;
    logic       fs_rx;
    logic       pwr_up;
    logic       tick_256k;
    logic       strobe_8k;
    logic [2:0] rate_code;
    logic       rate_bad;
    logic       standby;
    logic       tx_ready;

    int checks = 0;
    int fails  = 0;

    // Monitor state
    int cyc = 0;
    int cur_ticks = 0;
    int last_frame_ticks = 0;
    int last_strobe = 0;
    int strobe_gap = 0;
    int strobes = 0;
    int last_tick = 0;
    int have_prev = 0;
    int gap_min = 1000000;
    int gap_max = 0;
    int clr_gen = 0;
    int seen_gen = 0;

    always #5 clk = ~clk;

    frame_clock_gen u_frame_clock_gen (
        .mclk      (clk),
        .rst       (rst),
        .fs_tx     (fs_tx),
        .fs_rx     (fs_rx),
        .pwr_up    (pwr_up),
        .tick_256k (tick_256k),
        .strobe_8k (strobe_8k),
        .rate_code (rate_code),
        .rate_bad  (rate_bad),
        .standby   (standby),
        .tx_ready  (tx_ready)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (seen_gen != clr_gen) begin
            seen_gen  = clr_gen;
            have_prev = 0;
            gap_min   = 1000000;
            gap_max   = 0;
        end
        if (tick_256k) begin
            if (have_prev != 0) begin
                if (cyc - last_tick < gap_min) gap_min = cyc - last_tick;
                if (cyc - last_tick > gap_max) gap_max = cyc - last_tick;
            end
            have_prev = 1;
            last_tick = cyc;
        end
        if (strobe_8k) begin
            last_frame_ticks = cur_ticks;
            cur_ticks   = tick_256k ? 1 : 0;
            strobe_gap  = cyc - last_strobe;
            last_strobe = cyc;
            strobes     = strobes + 1;
        end else if (tick_256k) begin
            cur_ticks = cur_ticks + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nom(input int code);
        case (code)
            0: return 32;
            1: return 64;
            2: return 192;
            3: return 193;
            4: return 256;
            5: return 320;
            6: return 512;
            default: return 600;
        endcase
    endfunction

    // Drive n frames of length per, both syncs high for the first two cycles.
    task automatic frames(input int n, input int per);
        for (int f = 0; f < n; f++) begin
            for (int k = 0; k < per; k++) begin
                fs_tx = (k < 2);
                fs_rx = (k < 2);
                @(negedge clk);
            end
        end
    endtask

    task automatic check_lock(input int per, input int code, input string tag);
        int lo;
        int hi;
        lo = per / 32;
        hi = (per + 31) / 32;
        chk(rate_code == 3'(code) && !rate_bad, tag, int'(rate_code), code);
        chk(last_frame_ticks == 32, "R4 ticks per frame", last_frame_ticks, 32);
        chk(gap_min >= lo, "R4 min tick gap", gap_min, lo);
        chk(gap_max <= hi, "R4 max tick gap", gap_max, hi);
        chk(strobe_gap == per, "R5 strobe spacing", strobe_gap, per);
    endtask

    task automatic lock_at(input int per, input int code, input string tag);
        frames(4, per);
        clr_gen = clr_gen + 1;
        frames(2, per);
        check_lock(per, code, tag);
    endtask

    initial begin
        int s0;
        rst = 1'b1; fs_tx = 1'b0; fs_rx = 1'b0; pwr_up = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rate_bad == 1'b1, "R1 rate_bad", int'(rate_bad), 1);
        chk(rate_code == 3'd0, "R1 rate_code", int'(rate_code), 0);
        chk(!tick_256k && !strobe_8k, "R1 tick/strobe", int'(tick_256k | strobe_8k), 0);
        chk(!standby && !tx_ready, "R1 standby/tx_ready", int'(standby | tx_ready), 0);

        // R2 sweep of every nominal rate
        for (int c = 0; c < 8; c++) lock_at(nom(c), c, "R2 rate code");
        chk(tx_ready == 1'b1, "R9 ready after reset", int'(tx_ready), 1);

        // R3 tolerance edges and overlap resolution
        lock_at(191, 2, "R3 191 -> code 2");
        lock_at(194, 3, "R3 194 -> code 3");
        lock_at(192, 2, "R3 192 exact");
        lock_at(599, 7, "R3 599 -> code 7");
        lock_at(33, 0, "R3 33 -> code 0");
        frames(6, 100);
        chk(rate_bad == 1'b1, "R3 unsupported 100", int'(rate_bad), 1);
        s0 = strobes;
        frames(2, 100);
        chk(strobes == s0, "R5 no strobe unlocked", strobes - s0, 0);

        // R6 single stray frame ignored
        lock_at(256, 4, "R6 lock 256");
        frames(1, 100);
        frames(1, 256);
        chk(rate_code == 3'd4 && !rate_bad, "R6 stray frame", int'(rate_code), 4);
        lock_at(256, 4, "R6 still locked");

        // R7 standby entry after nominal+2 idle cycles
        lock_at(64, 1, "R7 lock 64");
        fs_tx = 1'b1; fs_rx = 1'b1;
        @(negedge clk);
        fs_tx = 1'b0; fs_rx = 1'b0;
        repeat (65) @(negedge clk);
        chk(standby == 1'b0, "R7 before limit", int'(standby), 0);
        @(negedge clk);
        chk(standby == 1'b1, "R7 at limit", int'(standby), 1);
        chk(tx_ready == 1'b0, "R9 cleared by standby", int'(tx_ready), 0);
        s0 = strobes;
        repeat (100) @(negedge clk);
        chk(strobes == s0, "R7 quiet in standby", strobes - s0, 0);

        // R8 wake on fs_tx, R9 ready on third edge
        frames(1, 64);
        chk(standby == 1'b0, "R8 wake", int'(standby), 0);
        frames(1, 64);
        chk(tx_ready == 1'b0, "R9 after two edges", int'(tx_ready), 0);
        frames(1, 64);
        chk(tx_ready == 1'b1, "R9 after third edge", int'(tx_ready), 1);

        // R7 receive sync alone keeps block awake
        lock_at(64, 1, "R7 relock");
        fs_tx = 1'b0;
        for (int k = 0; k < 300; k++) begin
            fs_rx = (k % 40 == 0);
            @(negedge clk);
        end
        chk(standby == 1'b0, "R7 rx activity", int'(standby), 0);
        fs_rx = 1'b0;
        frames(1, 64);
        lock_at(64, 1, "R7 after rx only");

        // R10 power down
        pwr_up = 1'b0;
        #1;
        chk(standby == 1'b1, "R10 standby immediate", int'(standby), 1);
        s0 = strobes;
        frames(3, 64);
        chk(strobes == s0, "R10 no strobes", strobes - s0, 0);
        chk(tx_ready == 1'b0, "R10 tx_ready low", int'(tx_ready), 0);
        pwr_up = 1'b1;
        frames(2, 64);
        chk(tx_ready == 1'b0, "R9 two edges after power-up", int'(tx_ready), 0);
        frames(1, 64);
        chk(tx_ready == 1'b1, "R9 three edges after power-up", int'(tx_ready), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails = fails + 1;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule